// File: doc/BRIEF.md
# ADC Alternating Input Sequencer

This block decides, for every sample/convert cycle of an external successive-approximation converter, which analog input feeds the sample/hold. Two selection sets exist. Set A and set B each hold a 4-bit positive channel and a one-bit negative-input select. With alternation on, samples interleave A, B, A, B. With scanning on, the set A positive input walks through the channels enabled in a 16-bit mask, while set B keeps its fixed channel. Acquisition starts by itself or on a software request. Conversion starts either after a programmed acquisition time or when software ends acquisition.

Each converter result is written into an internal 16-word store made of two 8-word halves. After a programmable number N of samples (1 to 16), the block pulses an interrupt and moves writing to the other half. A flag shows which half is being filled. Dropping the enable aborts the sequence and returns all sequencing state to its start, so that the next sequence begins with a set A sample.

The controller is a state machine with six states:
- `ST_OFF`: disabled.
- `ST_WAIT`: waiting for a software start.
- `ST_ACQ`: acquiring.
- `ST_START`: a one-cycle conversion start.
- `ST_CONV`: waiting for the converter.
- `ST_STORE`: a one-cycle result write.

Transitions:
- OFF→ACQ when enabled with auto-sample on, and OFF→WAIT when enabled without it.
- WAIT→ACQ on `samp_set`.
- ACQ→START when the acquisition timer expires. In fully manual mode this happens on `samp_clr` instead.
- START→CONV always.
- CONV→STORE on `conv_done`.
- STORE→ACQ with auto-sample on, and STORE→WAIT without it.
- Any state goes to OFF when `en` is low.

Top module: `adc_alt_seq`

## Requirements
- R1: With `alt_en`=0 every conversion uses `ch_pos`=`a_pos` and `ch_neg`=`a_neg`. When `scan_en`=1, the scan choice of R4 replaces `a_pos`.
- R2: With `alt_en`=1 the conversions after enable use set A, set B, set A, set B, and so on, starting with set A.
- R3: A set B conversion presents `ch_pos`=`b_pos` and `ch_neg`=`b_neg`. `ch_neg`=1 means the negative input is an analog channel, which makes the source differential. `ch_neg`=0 means the low reference.
- R4: With `scan_en`=1, a set A conversion uses the lowest enabled channel of `scan_mask` at or above the scan pointer, wrapping cyclically. The pointer then becomes that channel plus one, modulo 16. An all-zero mask gives channel 0. The pointer starts at 0.
- R5: In scan-plus-alternate mode a set B conversion uses `b_pos` and leaves the scan pointer unchanged.
- R6: The k-th result since the last interrupt (k counted from 0) is written to word (8·`fill_half` + k) mod 16 of the store, readable at `rd_data` for `rd_addr`. The result stored is the `conv_data` present with `conv_done`.
- R7: With N = `int_sel`+1, `irq` is a one-cycle pulse in the cycle after the N-th result is written. `fill_half` toggles at that same edge.
- R8: With `manual_conv`=0, `sampling` is high for exactly `samp_time`+1 cycles. `conv_start` is high in the single cycle after it drops. With `auto_sample`=1, acquisition restarts in the cycle after the result write.
- R9: With `auto_sample`=0, `sampling` stays low after a conversion and after enable until `samp_set` is sampled high. It rises in the next cycle.
- R10: With `manual_conv`=1, acquisition lasts until `samp_clr` is sampled high, whatever `samp_time` holds. `conv_start` is high in the next cycle.
- R11: `en`=0 returns to OFF and clears the A/B phase, the scan pointer, the sample count and `fill_half`. A result whose write cycle meets `en`=0 is dropped with no `irq`. The first conversion after re-enable uses set A.
- R12: After reset `sampling`, `conv_start`, `irq` and `fill_half` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Sequencer enable; low aborts and clears |
| alt_en | input | 1 | Alternate between set A and set B |
| scan_en | input | 1 | Set A positive input from the scan mask |
| auto_sample | input | 1 | Restart acquisition automatically |
| manual_conv | input | 1 | Conversion starts on `samp_clr` instead of the timer |
| a_pos | input | 4 | Set A positive channel |
| a_neg | input | 1 | Set A negative-input select |
| b_pos | input | 4 | Set B positive channel |
| b_neg | input | 1 | Set B negative-input select |
| scan_mask | input | 16 | Channels enabled for scanning |
| int_sel | input | 4 | Samples per interrupt minus one |
| samp_time | input | 8 | Acquisition length minus one, in cycles |
| samp_set | input | 1 | Software start of acquisition |
| samp_clr | input | 1 | Software end of acquisition |
| sampling | output | 1 | Sample/hold is acquiring |
| ch_pos | output | 4 | Selected positive channel |
| ch_neg | output | 1 | Selected negative-input select |
| conv_start | output | 1 | One-cycle conversion start |
| conv_done | input | 1 | Converter result valid |
| conv_data | input | 10 | Converter result |
| irq | output | 1 | Interrupt pulse |
| fill_half | output | 1 | Store half being written |
| rd_addr | input | 4 | Result store read address |
| rd_data | output | 10 | Result store read data |

## Verification
The enable can fall in the very cycle in which a result is written and an interrupt would be raised. The bench provokes this by lowering `en` right after the second `conv_done` of an alternating sequence with N=1, so that the drop lands in the write cycle. It then requires that no `irq` pulse appears and that `fill_half` is back at 0, even though the first sample had flipped it. After re-enable, the first conversion must again present the set A channel, not the set B channel the aborted phase would have led to.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAIT,
        ST_ACQ,
        ST_START,
        ST_CONV,
        ST_STORE
    } seq_state_e;
endpackage

// File: rtl/adc_scan_pick.sv
// Rotating priority search: lowest enabled channel at or above ptr, cyclic.
module adc_scan_pick #(
    parameter int NCH = 16,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic [NCH-1:0]  mask,
    input  logic [CH_W-1:0] ptr,
    output logic [CH_W-1:0] ch
);
    logic [CH_W-1:0] cand;

    always_comb begin
        ch   = '0;
        cand = '0;
        for (int k = NCH - 1; k >= 0; k--) begin
            cand = ptr + CH_W'(k);
            if (mask[cand]) begin
                ch = cand;
            end
        end
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int TIME_W = 8,
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              auto_sample,
    input  logic              manual_conv,
    input  logic              samp_set,
    input  logic              samp_clr,
    input  logic [TIME_W-1:0] samp_time,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              sampling,
    output logic              conv_start,
    output logic              store_fire,
    output logic [DATA_W-1:0] result
);
    seq_state_e        state, nxt;
    logic [TIME_W-1:0] tcnt;
    logic              acq_end;

    assign acq_end = manual_conv ? samp_clr : (tcnt == samp_time);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (!en) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:   nxt = auto_sample ? ST_ACQ : ST_WAIT;
                ST_WAIT:  nxt = samp_set ? ST_ACQ : ST_WAIT;
                ST_ACQ:   nxt = acq_end ? ST_START : ST_ACQ;
                ST_START: nxt = ST_CONV;
                ST_CONV:  nxt = conv_done ? ST_STORE : ST_CONV;
                ST_STORE: nxt = auto_sample ? ST_ACQ : ST_WAIT;
                default:  nxt = ST_OFF;
            endcase
        end
    end

    // acquisition timer, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt <= '0;
        end else if (state == ST_ACQ && nxt == ST_ACQ) begin
            if (tcnt != {TIME_W{1'b1}}) tcnt <= tcnt + 1'b1;
        end else begin
            tcnt <= '0;
        end
    end

    // converter result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             result <= '0;
        else if (state == ST_CONV && conv_done) result <= conv_data;
    end

    // outputs
    always_comb begin
        sampling   = (state == ST_ACQ);
        conv_start = (state == ST_START);
        store_fire = (state == ST_STORE) && en;
    end

    assert_start_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    assert_acq_then_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sampling && en && !manual_conv && tcnt == samp_time) |=> conv_start);
    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE && en && !auto_sample) |=> (state == ST_WAIT && !sampling));
    assert_manual_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sampling && en && manual_conv && !samp_clr) |=> sampling);
    assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_OFF && !sampling && !conv_start));
endmodule

// File: rtl/adc_seq_track.sv
module adc_seq_track #(
    parameter int NCH        = 16,
    parameter int HALF_WORDS = 8,
    parameter int MAX_N      = 16,
    localparam int CH_W   = $clog2(NCH),
    localparam int CNT_W  = $clog2(MAX_N),
    localparam int ADDR_W = $clog2(2 * HALF_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              alt_en,
    input  logic              scan_en,
    input  logic [CH_W-1:0]   a_pos,
    input  logic              a_neg,
    input  logic [CH_W-1:0]   b_pos,
    input  logic              b_neg,
    input  logic [NCH-1:0]    scan_mask,
    input  logic [CNT_W-1:0]  int_sel,
    input  logic              store_fire,
    output logic [CH_W-1:0]   ch_pos,
    output logic              ch_neg,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              irq,
    output logic              fill_half
);
    logic              phase;
    logic              use_b;
    logic [CH_W-1:0]   scan_ptr;
    logic [CH_W-1:0]   pick_ch;
    logic [CNT_W-1:0]  idx;
    logic [ADDR_W-1:0] half_base;

    adc_scan_pick #(.NCH(NCH)) u_pick (
        .mask (scan_mask),
        .ptr  (scan_ptr),
        .ch   (pick_ch)
    );

    always_comb begin
        use_b     = alt_en & phase;
        ch_pos    = use_b ? b_pos : (scan_en ? pick_ch : a_pos);
        ch_neg    = use_b ? b_neg : a_neg;
        half_base = fill_half ? ADDR_W'(HALF_WORDS) : '0;
        wr_addr   = half_base + ADDR_W'(idx);
        wr_en     = store_fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase     <= 1'b0;
            scan_ptr  <= '0;
            idx       <= '0;
            fill_half <= 1'b0;
            irq       <= 1'b0;
        end else if (!en) begin
            phase     <= 1'b0;
            scan_ptr  <= '0;
            idx       <= '0;
            fill_half <= 1'b0;
            irq       <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (store_fire) begin
                phase <= alt_en ? ~phase : 1'b0;
                if (!use_b && scan_en) scan_ptr <= pick_ch + 1'b1;
                if (idx == int_sel) begin
                    idx       <= '0;
                    fill_half <= ~fill_half;
                    irq       <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    assert_alternate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (store_fire && alt_en) |=> (phase != $past(phase)));
    assert_pick_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_mask != '0) |-> scan_mask[pick_ch]);
    assert_scan_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (store_fire && scan_en && !use_b) |=> (scan_ptr == CH_W'($past(pick_ch) + 1'b1)));
    assert_b_keeps_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (store_fire && use_b) |=> $stable(scan_ptr));
    assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    assert_half_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (fill_half != $past(fill_half)));
    assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (idx == '0 && !fill_half && !phase && scan_ptr == '0 && !irq));
endmodule

// File: rtl/adc_result_store.sv
module adc_result_store #(
    parameter int DATA_W = 10,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/adc_alt_seq.sv
module adc_alt_seq #(
    parameter int NCH        = 16,
    parameter int HALF_WORDS = 8,
    parameter int MAX_N      = 16,
    parameter int TIME_W     = 8,
    parameter int DATA_W     = 10,
    localparam int CH_W   = $clog2(NCH),
    localparam int CNT_W  = $clog2(MAX_N),
    localparam int DEPTH  = 2 * HALF_WORDS,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              alt_en,
    input  logic              scan_en,
    input  logic              auto_sample,
    input  logic              manual_conv,
    input  logic [CH_W-1:0]   a_pos,
    input  logic              a_neg,
    input  logic [CH_W-1:0]   b_pos,
    input  logic              b_neg,
    input  logic [NCH-1:0]    scan_mask,
    input  logic [CNT_W-1:0]  int_sel,
    input  logic [TIME_W-1:0] samp_time,
    input  logic              samp_set,
    input  logic              samp_clr,
    output logic              sampling,
    output logic [CH_W-1:0]   ch_pos,
    output logic              ch_neg,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              irq,
    output logic              fill_half,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic              store_fire;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] result;

    adc_seq_fsm #(.TIME_W(TIME_W), .DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .auto_sample (auto_sample),
        .manual_conv (manual_conv),
        .samp_set    (samp_set),
        .samp_clr    (samp_clr),
        .samp_time   (samp_time),
        .conv_done   (conv_done),
        .conv_data   (conv_data),
        .sampling    (sampling),
        .conv_start  (conv_start),
        .store_fire  (store_fire),
        .result      (result)
    );

    adc_seq_track #(.NCH(NCH), .HALF_WORDS(HALF_WORDS), .MAX_N(MAX_N)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .alt_en     (alt_en),
        .scan_en    (scan_en),
        .a_pos      (a_pos),
        .a_neg      (a_neg),
        .b_pos      (b_pos),
        .b_neg      (b_neg),
        .scan_mask  (scan_mask),
        .int_sel    (int_sel),
        .store_fire (store_fire),
        .ch_pos     (ch_pos),
        .ch_neg     (ch_neg),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .irq        (irq),
        .fill_half  (fill_half)
    );

    adc_result_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (result),
        .raddr (rd_addr),
        .rdata (rd_data)
    );
endmodule

// File: tb/sim_adc_alt_seq.sv
module sim_adc_alt_seq;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, alt_en = 1'b0, scan_en = 1'b0, auto_sample = 1'b0, manual_conv = 1'b0;
    logic [3:0]  a_pos = '0, b_pos = '0, int_sel = '0, rd_addr = '0;
    logic        a_neg = 1'b0, b_neg = 1'b0;
    logic [15:0] scan_mask = '0;
    logic [7:0]  samp_time = '0;
    logic        samp_set = 1'b0, samp_clr = 1'b0;
    logic        conv_done = 1'b0;
    logic [9:0]  conv_data = '0;
    logic        sampling, ch_neg, conv_start, irq, fill_half;
    logic [3:0]  ch_pos;
    logic [9:0]  rd_data;

    always #2 clk = ~clk;

    adc_alt_seq u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .alt_en(alt_en), .scan_en(scan_en),
        .auto_sample(auto_sample), .manual_conv(manual_conv),
        .a_pos(a_pos), .a_neg(a_neg), .b_pos(b_pos), .b_neg(b_neg),
        .scan_mask(scan_mask), .int_sel(int_sel), .samp_time(samp_time),
        .samp_set(samp_set), .samp_clr(samp_clr), .sampling(sampling),
        .ch_pos(ch_pos), .ch_neg(ch_neg), .conv_start(conv_start),
        .conv_done(conv_done), .conv_data(conv_data), .irq(irq),
        .fill_half(fill_half), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    int checks = 0, failures = 0, finished = 0;
    int done_cnt = 0, cnv_n = 0, mdl_n = 0;
    int m_phase = 0, m_ptr = 0, m_idx = 0, m_half = 0, m_irq = 0, obs_irq = 0, m_first = 0;
    int chk_on = 0, timed_chk = 0, run_len = 0;
    logic [9:0] exp_mem [16];
    bit         exp_valid [16];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int pick(input logic [15:0] m, input int p);
        if (m == 16'h0) return 0;
        for (int i = 0; i < 16; i++) begin
            if (m[(p + i) % 16]) return (p + i) % 16;
        end
        return 0;
    endfunction

    // converter model
    initial begin
        int lat;
        logic [3:0] cp;
        logic cn;
        int cs;
        lat = 0; cp = '0; cn = 1'b0; cs = 0;
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (lat > 0) begin
                lat--;
                if (lat == 0) begin
                    conv_data = {cs[4:0], cn, cp};
                    conv_done = 1'b1;
                    done_cnt++;
                end
            end
            if (conv_start === 1'b1) begin
                lat = LAT; cp = ch_pos; cn = ch_neg; cs = cnv_n; cnv_n++;
            end
        end
    end

    // monitor and reference model
    initial begin
        bit isb;
        logic [3:0] ep;
        logic eneg;
        int a;
        string req;
        forever begin
            @(negedge clk);
            if (conv_start === 1'b1) begin
                if (chk_on != 0) begin
                    isb = (alt_en == 1'b1) && (m_phase != 0);
                    if (isb) begin
                        ep = b_pos; eneg = b_neg;
                    end else begin
                        eneg = a_neg;
                        if (scan_en) begin
                            ep = 4'(pick(scan_mask, m_ptr));
                            m_ptr = (int'(ep) + 1) % 16;
                        end else ep = a_pos;
                    end
                    if (m_first != 0) req = "R11";
                    else if (scan_en) req = isb ? "R5" : "R4";
                    else if (isb) req = "R3";
                    else req = alt_en ? "R2" : "R1";
                    chk(ch_pos == ep && ch_neg == eneg, req, "channel {neg,pos}",
                        int'({ch_neg, ch_pos}), int'({eneg, ep}));
                    m_first = 0;
                    m_phase = alt_en ? 1 - m_phase : 0;
                    a = (m_half * 8 + m_idx) % 16;
                    exp_mem[a] = {5'(mdl_n), eneg, ep};
                    exp_valid[a] = 1'b1;
                    m_idx++;
                    if (m_idx == int'(int_sel) + 1) begin
                        m_idx = 0; m_half = 1 - m_half; m_irq++;
                    end
                end
                mdl_n++;
            end
            if (irq === 1'b1 && chk_on != 0) begin
                obs_irq++;
                chk(obs_irq == m_irq, "R7", "irq after N samples", obs_irq, m_irq);
                chk(int'(fill_half) == m_half, "R7", "fill_half toggles with irq", int'(fill_half), m_half);
            end
            if (sampling === 1'b1) run_len++;
            else if (run_len > 0) begin
                if (timed_chk != 0) begin
                    chk(run_len == int'(samp_time) + 1, "R8", "acquisition length", run_len, int'(samp_time) + 1);
                    chk(conv_start === 1'b1, "R8", "conv_start after acquisition", int'(conv_start), 1);
                end
                run_len = 0;
            end
        end
    end

    task automatic reset_model();
        m_phase = 0; m_ptr = 0; m_idx = 0; m_half = 0; m_irq = 0; obs_irq = 0; m_first = 1;
        for (int i = 0; i < 16; i++) exp_valid[i] = 1'b0;
    endtask

    task automatic restart(input int timed);
        reset_model();
        run_len = 0;
        chk_on = 1;
        timed_chk = timed;
        en = 1'b1;
    endtask

    task automatic start_run(input int alt, input int scn, input int msk, input int ap, input int an,
                             input int bp, input int bn, input int nsel, input int st,
                             input int aut, input int man);
        @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
        alt_en = 1'(alt); scan_en = 1'(scn); scan_mask = 16'(msk);
        a_pos = 4'(ap); a_neg = 1'(an); b_pos = 4'(bp); b_neg = 1'(bn);
        int_sel = 4'(nsel); samp_time = 8'(st);
        auto_sample = 1'(aut); manual_conv = 1'(man);
        restart(man == 0 ? 1 : 0);
    endtask

    task automatic end_run(input int target);
        while (done_cnt < target) @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        timed_chk = 0;
        en = 1'b0;
        repeat (2) @(negedge clk);
        chk_on = 0;
        chk(obs_irq == m_irq, "R7", "interrupt count of run", obs_irq, m_irq);
        for (int a = 0; a < 16; a++) begin
            if (exp_valid[a]) begin
                rd_addr = 4'(a);
                #1;
                chk(rd_data == exp_mem[a], "R6", "stored word", int'(rd_data), int'(exp_mem[a]));
            end
        end
    endtask

    task automatic pulse_set();
        @(negedge clk); samp_set = 1'b1;
        @(negedge clk); samp_set = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); samp_clr = 1'b1;
        @(negedge clk); samp_clr = 1'b0;
    endtask

    initial begin
        int base;
        void'($urandom(32'd7351));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(sampling == 1'b0, "R12", "sampling after reset", int'(sampling), 0);
        chk(conv_start == 1'b0, "R12", "conv_start after reset", int'(conv_start), 0);
        chk(irq == 1'b0, "R12", "irq after reset", int'(irq), 0);
        chk(fill_half == 1'b0, "R12", "fill_half after reset", int'(fill_half), 0);

        // R1: single set, interrupt every sample
        start_run(0, 0, 0, 6, 1, 9, 0, 0, 2, 1, 0);
        end_run(done_cnt + 10);
        // R2 / R3: alternating with differential set B, N=4
        start_run(1, 0, 0, 2, 0, 11, 1, 3, 1, 1, 0);
        end_run(done_cnt + 12);
        // R4 / R5: scan plus alternate with wrap
        start_run(1, 1, 16'h8421, 7, 0, 4, 1, 7, 0, 1, 0);
        end_run(done_cnt + 14);
        // R4: empty mask selects channel 0
        start_run(0, 1, 0, 13, 0, 3, 0, 2, 0, 1, 0);
        end_run(done_cnt + 6);
        // R6: N=16 spills over both halves
        start_run(1, 0, 0, 1, 1, 14, 0, 15, 0, 1, 0);
        end_run(done_cnt + 20);

        // R9 / R10: fully manual sampling
        start_run(0, 0, 0, 5, 0, 8, 0, 0, 2, 0, 1);
        repeat (5) @(negedge clk);
        chk(sampling == 1'b0, "R9", "no acquisition before samp_set", int'(sampling), 0);
        pulse_set();
        chk(sampling == 1'b1, "R9", "acquisition after samp_set", int'(sampling), 1);
        repeat (10) @(negedge clk);
        chk(sampling == 1'b1, "R10", "acquisition held past samp_time", int'(sampling), 1);
        pulse_clr();
        chk(conv_start == 1'b1, "R10", "conv_start after samp_clr", int'(conv_start), 1);
        chk(sampling == 1'b0, "R10", "acquisition ended by samp_clr", int'(sampling), 0);
        base = done_cnt;
        while (done_cnt < base + 1) @(posedge clk);
        repeat (8) @(negedge clk);
        chk(sampling == 1'b0, "R9", "no restart after conversion", int'(sampling), 0);
        chk(obs_irq == 1, "R7", "irq for manual sample", obs_irq, 1);
        pulse_set();
        repeat (3) @(negedge clk);
        pulse_clr();
        end_run(base + 2);

        // R11: enable dropped in the write cycle of the second sample
        start_run(1, 0, 0, 3, 0, 9, 1, 0, 1, 1, 0);
        base = done_cnt;
        while (done_cnt < base + 2) @(posedge clk);
        @(negedge clk);
        en = 1'b0; chk_on = 0; timed_chk = 0;
        @(negedge clk);
        chk(irq == 1'b0, "R11", "no irq for aborted write", int'(irq), 0);
        chk(fill_half == 1'b0, "R11", "fill_half cleared", int'(fill_half), 0);
        chk(sampling == 1'b0, "R11", "sequencer off", int'(sampling), 0);
        @(negedge clk);
        restart(1);
        end_run(done_cnt + 3);

        // constrained random configurations
        for (int r = 0; r < 8; r++) begin
            int msk;
            msk = ($urandom % 4 == 0) ? 0 : int'($urandom % 65536);
            start_run(int'($urandom % 2), int'($urandom % 2), msk, int'($urandom % 16), int'($urandom % 2),
                      int'($urandom % 16), int'($urandom % 2), int'($urandom % 16), int'($urandom % 4), 1, 0);
            end_run(done_cnt + 24);
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (finished == 0) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule